// File: doc/BRIEF.md
# Serial-Grant Bus Arbiter

This block decides which of N requesters (default 4) owns a shared bus. Every requester drives its own request input, and the block merges these into one combined request that a small central controller watches. When the bus is idle and the combined request is high, the controller launches a single grant into the head of a chain of per-device slices. The grant travels from slice 0 towards slice N-1. Each slice can do one of two things with it: keep it, if that device is asking for the bus, or hand it on to the next slice.

Priority therefore comes only from position in the chain. Slice 0 always wins a contest and slice N-1 always loses. A device that keeps the grant latches ownership and holds the bus until the shared release input is raised. The block outputs a one-hot grant vector and a busy flag. Nothing in the scheme protects the last devices from being locked out for as long as devices ahead of them keep asking.

Top module: `dchain_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `dev_grant` all zero and `bus_busy` low.
- R2: From idle, a request on any device produces exactly one owner in `dev_grant` two clock edges after the edge that first sees the request. The first edge launches the chain grant and the second latches ownership.
- R3: When several devices request in the cycle the grant is launched, ownership goes to the lowest-numbered requesting device. Bit i of `dev_grant` stands for device i.
- R4: An owner keeps its `dev_grant` bit unchanged until release, even if a higher-priority device starts requesting after ownership was taken.
- R5: `bus_release` sampled high while a device owns the bus clears `dev_grant` at the next edge. Raised while nobody owns the bus, it has no effect on `dev_grant`, `bus_busy` or the next grant.
- R6: At most one `dev_grant` bit is ever high, and `bus_busy` is high exactly when one is.
- R7: If every request is withdrawn before the launched grant is absorbed, the grant runs off the end of the chain. The block then returns to idle with no owner.
- R8: A lower-priority device is starved indefinitely while a higher-priority device keeps requesting. It gets the bus once the higher-priority requests stop.
- R9: A device becomes owner only if its request was high in the cycle before its `dev_grant` bit rises. No device uses the bus without having received the chain grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N | Per-device bus request, bit 0 highest priority |
| bus_release | input | 1 | Shared line raised by the owner when it is done |
| dev_grant | output | N | One-hot ownership, bit i for device i |
| bus_busy | output | 1 | High while some device owns the bus |

## Verification
The properties assume that `bus_release` only has meaning while a device owns the bus. They also assume that requests may change freely at any cycle, including during the one-cycle window where the launched grant is being absorbed. The random stimulus changes requests and release every cycle with no protocol discipline, so release pulses land on idle and offer cycles as well as on held ones. Directed sequences then pin down withdrawal during the offer, late upstream requests, and a long starvation run of the last device.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OFFER = 2'd1,
        ARB_HOLD  = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic chain_grant;
        logic capture;
        logic clear;
        logic busy;
    } ctl_out_t;

    function automatic logic merge_requests(input logic [31:0] reqs, input int unsigned count);
        logic acc;
        acc = 1'b0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < count) acc = acc | reqs[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
    import dchain_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     any_req,
    input  logic     chain_tail,
    input  logic     bus_release,
    output ctl_out_t ctl
);

    arb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (any_req) state_d = ARB_OFFER;
            ARB_OFFER: state_d = chain_tail ? ARB_IDLE : ARB_HOLD;
            ARB_HOLD:  if (bus_release) state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        ctl.chain_grant = (state_q != ARB_IDLE);
        ctl.capture     = (state_q == ARB_OFFER);
        ctl.clear       = (state_q == ARB_HOLD) && bus_release;
        ctl.busy        = (state_q == ARB_HOLD);
    end

endmodule

// File: rtl/dchain_slice.sv
module dchain_slice (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic grant_in,
    input  logic capture,
    input  logic clear,
    output logic grant_out,
    output logic owner
);

    logic owner_q;
    logic absorb;

    // Keep the grant if already owner, or if requesting while the offer is live.
    assign absorb    = grant_in && (owner_q || (req && capture));
    assign grant_out = grant_in && !absorb;
    assign owner     = owner_q;

    always_ff @(posedge clk) begin
        if (rst || clear)             owner_q <= 1'b0;
        else if (absorb && capture)   owner_q <= 1'b1;
    end

endmodule

// File: rtl/dchain_arbiter.sv
module dchain_arbiter #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] dev_req,
    input  logic         bus_release,
    output logic [N-1:0] dev_grant,
    output logic         bus_busy
);
    import dchain_pkg::*;

    localparam int unsigned LINKS = N + 1;

    logic [LINKS-1:0] link;
    logic             any_req;
    ctl_out_t         ctl;

    assign any_req = merge_requests(32'(dev_req), N);

    dchain_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .any_req    (any_req),
        .chain_tail (link[N]),
        .bus_release(bus_release),
        .ctl        (ctl)
    );

    assign link[0] = ctl.chain_grant;

    for (genvar i = 0; i < N; i++) begin : g_slice
        dchain_slice u_slice (
            .clk      (clk),
            .rst      (rst),
            .req      (dev_req[i]),
            .grant_in (link[i]),
            .capture  (ctl.capture),
            .clear    (ctl.clear),
            .grant_out(link[i+1]),
            .owner    (dev_grant[i])
        );
    end

    assign bus_busy = ctl.busy;

endmodule

// File: rtl/dchain_arbiter_chk.sv
module dchain_arbiter_chk #(
    parameter int unsigned N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] dev_req,
    input logic         bus_release,
    input logic [N-1:0] dev_grant,
    input logic         bus_busy
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dev_grant == '0 && !bus_busy));

    p_one_owner_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_grant));

    p_busy_tracks_r6: assert property (@(posedge clk) disable iff (rst)
        bus_busy == (dev_grant != '0));

    p_hold_owner_r4: assert property (@(posedge clk) disable iff (rst)
        (dev_grant != '0 && !bus_release) |=> dev_grant == $past(dev_grant));

    p_release_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (dev_grant != '0 && bus_release) |=> dev_grant == '0);

    p_owner_requested_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy) |-> (($past(dev_req) & dev_grant) != '0));

    p_no_req_no_take_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && dev_req == '0) |=> !bus_busy);

endmodule

bind dchain_arbiter dchain_arbiter_chk #(.N(N)) u_chk (.*);

// File: tb/dchain_arbiter_bench.sv
`timescale 1ns/1ps
module dchain_arbiter_bench;

    localparam int unsigned N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] dev_req;
    logic         bus_release;
    logic [N-1:0] dev_grant;
    logic         bus_busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // model: 0 idle, 1 offer, 2 hold
    int m_state = 0;
    int m_owner = -1;
    string m_tag = "R1";

    always #4 clk = ~clk;

    dchain_arbiter #(.N(N)) u_dchain_arbiter (
        .clk(clk), .rst(rst), .dev_req(dev_req), .bus_release(bus_release),
        .dev_grant(dev_grant), .bus_busy(bus_busy)
    );

    function automatic int first_req(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic logic [N-1:0] exp_grant(input int owner);
        return (owner < 0) ? '0 : (N'(1) << owner);
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_state = 0; m_owner = -1; m_tag = "R1";
        end else begin
            case (m_state)
                0: begin
                    m_tag = bus_release ? "R5" : "R2";
                    if (dev_req != '0) m_state = 1;
                end
                1: begin
                    m_owner = first_req(dev_req);
                    if (m_owner < 0) begin m_state = 0; m_tag = "R7"; end
                    else begin m_state = 2; m_tag = "R3"; end
                end
                default: begin
                    if (bus_release) begin m_state = 0; m_owner = -1; m_tag = "R5"; end
                    else m_tag = "R4";
                end
            endcase
        end
    endtask

    task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_vec(m_tag, dev_grant, exp_grant(m_owner));
        check_vec("R6", {{(N-1){1'b0}}, bus_busy}, {{(N-1){1'b0}}, (m_state == 2)});
    endtask

    task automatic drive(input logic [N-1:0] r, input logic rel);
        dev_req = r; bus_release = rel;
        tick();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R2 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d3_wins;
        int d0_wins;
        void'($urandom(32'd20240611));
        rst = 1'b1; dev_req = '0; bus_release = 1'b0;
        @(negedge clk);
        tick();
        tick();
        // R1: reset state
        check_vec("R1", dev_grant, '0);
        rst = 1'b0;

        // R2: lone request from idle, owner two edges later
        drive(4'b0100, 1'b0);
        check_vec("R2", dev_grant, '0);
        drive(4'b0100, 1'b0);
        check_vec("R2", dev_grant, 4'b0100);
        // R4: higher-priority request after take-over does not preempt
        drive(4'b0101, 1'b0);
        drive(4'b0001, 1'b0);
        check_vec("R4", dev_grant, 4'b0100);
        // R5: release frees the bus; R3: pending device 0 wins next
        drive(4'b1001, 1'b1);
        check_vec("R5", dev_grant, '0);
        drive(4'b1001, 1'b0);
        drive(4'b1001, 1'b0);
        check_vec("R3", dev_grant, 4'b0001);
        drive(4'b0000, 1'b1);
        // R5: release while idle has no effect
        drive(4'b0000, 1'b1);
        drive(4'b0000, 1'b1);
        check_vec("R5", dev_grant, '0);
        // R7: request withdrawn before offer lands
        drive(4'b0010, 1'b0);
        drive(4'b0000, 1'b0);
        drive(4'b0000, 1'b0);
        check_vec("R7", dev_grant, '0);
        // R9: request moves during offer; grant follows who asks then
        drive(4'b0010, 1'b0);
        drive(4'b1000, 1'b0);
        check_vec("R9", dev_grant, 4'b1000);
        drive(4'b0000, 1'b1);

        // R8: starvation of device 3 while device 0 keeps asking
        d3_wins = 0; d0_wins = 0;
        for (int k = 0; k < 60; k++) begin
            drive(4'b1001, dev_grant != '0);
            if (dev_grant[3]) d3_wins++;
            if (dev_grant[0] && m_state == 2 && m_tag == "R3") d0_wins++;
        end
        check_vec("R8", N'(d3_wins), '0);
        check_vec("R8", N'(d0_wins != 0), N'(1));
        drive(4'b1000, 1'b1);
        drive(4'b1000, 1'b0);
        drive(4'b1000, 1'b0);
        drive(4'b1000, 1'b0);
        check_vec("R8", dev_grant, 4'b1000);
        drive(4'b0000, 1'b1);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] r;
            logic rel;
            r   = N'($urandom);
            rel = ($urandom % 4) == 0;
            if (k % 500 == 250) begin
                rst = 1'b1;
                drive(r, rel);
                rst = 1'b0;
            end else begin
                drive(r, rel);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule